// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block keeps the operating mode of a synchronous DRAM and turns every read or write command into the column address sequence of its burst. A mode-set strobe offers a 12-bit word; if that word is legal it becomes the active mode, and if it is not, a sticky error flag is raised and the previous mode stays in force. The active mode gives the burst length (1, 2, 4 or 8 beats, or a whole 256-column row), the wrap order (sequential or interleaved), the CAS latency and a switch that shortens writes to one beat.

A command supplies a starting column. From the next cycle on, the block emits one column per clock with a valid flag, and it raises a last flag on the final beat of a fixed-length burst. A fixed burst stays inside the aligned block of N columns that holds the start column. A full-row burst counts up modulo 256 until an abort input stops it. An abort, for example a burst stop or a precharge, ends any burst on the following clock. A fresh command restarts the sequence.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset the mode is burst length 1, sequential, CAS latency 2, writes bursting; `mode_err`=0, `col_valid`=0, `col_last`=0 and `cas_lat`=2.
- R2: A legal word on `mrs_data` with `mrs_valid` high is the active mode from the next cycle. Bits [2:0] hold the length code (000=1, 001=2, 010=4, 011=8, 111=full row). Bit 3 selects the order (0 sequential, 1 interleaved). Bits [6:4] hold the CAS latency (001..011 = 1..3), shown on `cas_lat` as 1..3. Bit 9 set makes writes single-beat.
- R3: A word is rejected if it has a length code of 100..110, code 111 with bit 3 set, a latency code of 000 or 1xx, or a one in bit 7, 8, 10 or 11. A rejected word sets `mode_err`, which then stays high until reset, and leaves the active mode and `cas_lat` unchanged.
- R4: A command in cycle t puts the start column on `col_addr` with `col_valid` high in cycle t+1. Beat k of the burst appears in cycle t+1+k.
- R5: In a fixed burst of N beats, every address keeps the start column's bits above log2(N) and never leaves that aligned block.
- R6: In sequential order, beat k has low bits (start + k) mod N.
- R7: In interleaved order, beat k has low bits (start low bits) XOR k.
- R8: `col_last` is high on beat N-1 only. Without a new command, `col_valid` is low in the cycle after that beat.
- R9: A full-row burst gives (start + k) mod 256 on beat k, keeps running and never raises `col_last`.
- R10: With length code 000, a command gives one beat at the given column with `col_last` high, whatever bit 3 holds.
- R11: With bit 9 set, every write is one beat with `col_last` high, and reads use the programmed length.
- R12: `abort` high without a command drops `col_valid` in the next cycle. A command in the same cycle takes priority.
- R13: A command arriving during a burst starts the new sequence from its own column in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mrs_valid | input | 1 | Mode-set strobe |
| mrs_data | input | 12 | Mode word offered with the strobe |
| cmd_valid | input | 1 | Read or write command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | 8 | Starting column of the command |
| abort | input | 1 | Ends the burst in progress |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cas_lat | output | 2 | Active CAS latency in cycles (1..3) |
| mode_err | output | 1 | Sticky flag for a rejected mode word |

## Verification
The bench targets start columns that sit in the middle or at the top of their block. A design that carried into the upper bits instead of wrapping would leave the aligned block there, and a design that added where it should XOR would get the interleaved order wrong. Full-row bursts begin near column 255, so a wrong counter width or a wrongly placed last flag shows up at the roll-over. Rejected words are sent after a distinctive mode has been set and are followed by a burst, which exposes a design that applies part of a bad word. Abort and command are driven in the same cycle, and commands arrive mid-burst, to catch a wrong priority or a stale beat counter.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

    typedef struct packed {
        logic [2:0] bl;   // length code
        logic       bt;   // 1 = interleaved order
        logic [2:0] cl;   // latency code
        logic       wb;   // 1 = writes single beat
    } mode_t;

    localparam mode_t MODE_RESET = '{bl: 3'b000, bt: 1'b0, cl: 3'b010, wb: 1'b0};
    localparam logic [2:0] BL_FULL  = 3'b111;
    localparam logic [2:0] BL_MAXFX = 3'b011;

endpackage

// File: rtl/sdram_mode_decode.sv
module sdram_mode_decode
    import sdram_col_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic [MODE_W-1:0] raw,
    output mode_t             mode,
    output logic              legal
);
    localparam int BL_LSB = 0;
    localparam int BT_BIT = 3;
    localparam int CL_LSB = 4;
    localparam int WB_BIT = 9;
    localparam logic [MODE_W-1:0] FIELD_MASK = MODE_W'(10'h27F);

    logic bl_ok;
    logic cl_ok;
    logic rsv_ok;

    always_comb begin
        mode.bl = raw[BL_LSB +: 3];
        mode.bt = raw[BT_BIT];
        mode.cl = raw[CL_LSB +: 3];
        mode.wb = raw[WB_BIT];
        bl_ok   = (mode.bl <= BL_MAXFX) || ((mode.bl == BL_FULL) && !mode.bt);
        cl_ok   = (mode.cl != 3'b000) && !mode.cl[2];
        rsv_ok  = ((raw & ~FIELD_MASK) == '0);
        legal   = bl_ok && cl_ok && rsv_ok;
    end
endmodule

// File: rtl/sdram_addr_gen.sv
module sdram_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] low;

    always_comb begin
        low  = ilv ? (start ^ beat) : (start + beat);
        addr = (start & ~mask) | (low & mask);
    end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import sdram_col_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_valid,
    input  logic [MODE_W-1:0] mrs_data,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              abort,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last,
    output logic [1:0]        cas_lat,
    output logic              mode_err
);
    typedef struct packed {
        mode_t            mode;
        logic             err;
        logic             run;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] addr;
        logic             valid;
        logic             last;
    } state_t;

    state_t s_d, s_q, s_rst;

    mode_t            dec_mode;
    logic             dec_legal;
    logic [COL_W-1:0] gen_addr;
    logic [COL_W-1:0] cmd_mask;
    logic             cmd_full;
    logic             single_wr;

    sdram_mode_decode #(.MODE_W(MODE_W)) u_dec (
        .raw   (mrs_data),
        .mode  (dec_mode),
        .legal (dec_legal)
    );

    sdram_addr_gen #(.COL_W(COL_W)) u_gen (
        .start (s_q.start),
        .beat  (s_q.beat),
        .mask  (s_q.mask),
        .ilv   (s_q.ilv),
        .addr  (gen_addr)
    );

    function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
        if (code == BL_FULL)
            return '1;
        else if (code <= BL_MAXFX)
            return COL_W'((1 << code) - 1);
        else
            return '0;
    endfunction

    always_comb begin
        s_rst      = '0;
        s_rst.mode = MODE_RESET;
    end

    always_comb begin
        s_d       = s_q;
        single_wr = cmd_write && s_q.mode.wb;
        cmd_mask  = single_wr ? '0 : len_mask(s_q.mode.bl);
        cmd_full  = !single_wr && (s_q.mode.bl == BL_FULL);

        if (mrs_valid) begin
            if (dec_legal)
                s_d.mode = dec_mode;
            else
                s_d.err = 1'b1;
        end

        if (cmd_valid) begin
            s_d.start = cmd_col;
            s_d.mask  = cmd_mask;
            s_d.full  = cmd_full;
            s_d.ilv   = s_q.mode.bt && !cmd_full;
            s_d.beat  = COL_W'(1);
            s_d.addr  = cmd_col;
            s_d.valid = 1'b1;
            s_d.last  = (cmd_mask == '0);
            s_d.run   = (cmd_mask != '0);
        end else if (abort) begin
            s_d.run   = 1'b0;
            s_d.valid = 1'b0;
            s_d.last  = 1'b0;
        end else if (s_q.run) begin
            s_d.addr  = gen_addr;
            s_d.valid = 1'b1;
            s_d.last  = !s_q.full && (s_q.beat == s_q.mask);
            s_d.run   = s_q.full || (s_q.beat != s_q.mask);
            s_d.beat  = s_q.beat + COL_W'(1);
        end else begin
            s_d.valid = 1'b0;
            s_d.last  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= s_rst;
        else
            s_q <= s_d;
    end

    assign col_addr  = s_q.addr;
    assign col_valid = s_q.valid;
    assign col_last  = s_q.last;
    assign cas_lat   = s_q.mode.cl[1:0];
    assign mode_err  = s_q.err;
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
    parameter int COL_W  = 8,
    parameter int MODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mrs_valid,
    input logic [MODE_W-1:0] mrs_data,
    input logic              cmd_valid,
    input logic [COL_W-1:0]  cmd_col,
    input logic              abort,
    input logic [COL_W-1:0]  col_addr,
    input logic              col_valid,
    input logic              col_last,
    input logic [1:0]        cas_lat,
    input logic              mode_err
);
    a_r8_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    a_r8_valid_drops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        col_last && !cmd_valid |=> !col_valid);

    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    a_r3_select_bit_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_valid && mrs_data[11] |=> mode_err && $stable(cas_lat));

    a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> col_valid && (col_addr == $past(cmd_col)));

    a_r12_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
        abort && !cmd_valid |=> !col_valid);

    a_r2_cas_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cas_lat != 2'd0);
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrs_valid (mrs_valid),
    .mrs_data  (mrs_data),
    .cmd_valid (cmd_valid),
    .cmd_col   (cmd_col),
    .abort     (abort),
    .col_addr  (col_addr),
    .col_valid (col_valid),
    .col_last  (col_last),
    .cas_lat   (cas_lat),
    .mode_err  (mode_err)
);

// File: tb/sdram_col_seq_test.sv
module sdram_col_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mrs_valid = 1'b0;
    logic [11:0] mrs_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_col = '0;
    logic        abort = 1'b0;
    logic [7:0]  col_addr;
    logic        col_valid;
    logic        col_last;
    logic [1:0]  cas_lat;
    logic        mode_err;

    int tests = 0;
    int fails = 0;

    int m_bl = 0, m_bt = 0, m_cl = 2, m_wb = 0, m_err = 0;

    sdram_col_seq uut (
        .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .mrs_data(mrs_data),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
        .abort(abort), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last), .cas_lat(cas_lat), .mode_err(mode_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input int bl, input int bt, input int cl, input int wb);
        return {2'b00, wb[0], 2'b00, cl[2:0], bt[0], bl[2:0]};
    endfunction

    function automatic bit is_legal(input logic [11:0] v);
        int bl = int'(v[2:0]);
        int cl = int'(v[6:4]);
        if (v[7] || v[8] || v[10] || v[11]) return 0;
        if (cl < 1 || cl > 3) return 0;
        if (bl <= 3) return 1;
        return (bl == 7) && !v[3];
    endfunction

    function automatic int exp_addr(input int col, input int k, input int n, input int bt);
        int m;
        if (n == 0) return (col + k) % 256;
        m = n - 1;
        if (bt != 0) return (col & ~m & 255) | ((col ^ k) & m);
        return (col & ~m & 255) | ((col + k) & m);
    endfunction

    task automatic do_mrs(input logic [11:0] v);
        bit ok = is_legal(v);
        @(negedge clk);
        mrs_valid = 1'b1;
        mrs_data  = v;
        @(negedge clk);
        mrs_valid = 1'b0;
        if (ok) begin
            m_bl = int'(v[2:0]); m_bt = int'(v[3]); m_cl = int'(v[6:4]); m_wb = int'(v[9]);
        end else begin
            m_err = 1;
        end
        chk(cas_lat == m_cl[1:0], ok ? "R2 cas_lat" : "R3 cas_lat kept", int'(cas_lat), m_cl);
        chk(mode_err == m_err[0], ok ? "R2 mode_err" : "R3 mode_err", int'(mode_err), m_err);
    endtask

    task automatic check_beat(input int k, input int col, input int n, input bit wr);
        int    ex = exp_addr(col, k, n, m_bt);
        bit    exl = (n != 0) && (k == n - 1);
        string tg;
        if (m_wb != 0)      tg = "R11";
        else if (n == 0)    tg = "R9";
        else if (n == 1)    tg = "R10";
        else if (m_bt != 0) tg = "R7";
        else                tg = "R6";
        chk(col_valid && (int'(col_addr) == ex), {tg, " addr"}, int'(col_addr), ex);
        chk(col_last == exl, "R8 last flag", int'(col_last), int'(exl));
        if (n > 1)
            chk((int'(col_addr) & ~(n - 1)) == (col & ~(n - 1)), "R5 block",
                int'(col_addr), col & ~(n - 1));
        if (wr && m_wb != 0)
            chk(n == 1, "R11 write single", n, 1);
    endtask

    // kind: 0 natural end, 1 abort after stop beats, 2 leave running after stop beats
    task automatic run_burst(input bit wr, input int col, input int kind, input int stop);
        int n = (wr && m_wb != 0) ? 1 : (m_bl == 7 ? 0 : (1 << m_bl));
        int total = (n == 0) ? stop : n;
        bit natural;
        if (kind != 0 && stop < total) total = stop;
        natural = (n != 0) && (total == n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_col = col[7:0];
        @(posedge clk); #1;
        check_beat(0, col, n, wr);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 1; k < total; k++) begin
            @(posedge clk); #1;
            check_beat(k, col, n, wr);
        end
        if (kind == 2) return;
        if (natural) begin
            @(posedge clk); #1;
            chk(!col_valid, "R8 valid after last", int'(col_valid), 0);
        end else begin
            @(negedge clk);
            abort = 1'b1;
            @(posedge clk); #1;
            chk(!col_valid, "R12 abort", int'(col_valid), 0);
            @(negedge clk);
            abort = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cas_lat == 2'd2, "R1 cas_lat", int'(cas_lat), 2);
        chk(!mode_err, "R1 mode_err", int'(mode_err), 0);
        chk(!col_valid && !col_last, "R1 valid/last", int'(col_valid), 0);
        run_burst(1'b1, 77, 0, 0);   // R1 single beat under reset mode

        // R2, R6, R5: sequential length 4 and 8
        do_mrs(mk(2, 0, 3, 0));
        run_burst(1'b0, 8'h2E, 0, 0);
        do_mrs(mk(3, 0, 1, 0));
        run_burst(1'b1, 8'hFD, 0, 0);
        // R7 interleave
        do_mrs(mk(3, 1, 2, 0));
        run_burst(1'b0, 8'h41, 0, 0);
        do_mrs(mk(1, 1, 3, 0));
        run_burst(1'b0, 8'h13, 0, 0);
        // R10 length one with interleave bit set
        do_mrs(mk(0, 1, 2, 0));
        run_burst(1'b0, 8'h9B, 0, 0);
        // R9 full row wrapping past 255
        do_mrs(mk(7, 0, 2, 0));
        run_burst(1'b0, 250, 1, 20);
        // R11 write single beat, read full length
        do_mrs(mk(3, 0, 2, 1));
        run_burst(1'b1, 8'h35, 0, 0);
        run_burst(1'b0, 8'h35, 0, 0);
        // R13 restart mid-burst
        do_mrs(mk(3, 1, 3, 0));
        run_burst(1'b0, 8'h06, 2, 3);
        run_burst(1'b0, 8'hA2, 0, 0);
        // R12 abort early, then abort together with a command
        run_burst(1'b0, 8'h10, 1, 2);
        run_burst(1'b0, 8'h20, 2, 2);
        @(negedge clk);
        abort = 1'b1; cmd_valid = 1'b1; cmd_col = 8'h55; cmd_write = 1'b0;
        @(posedge clk); #1;
        chk(col_valid && col_addr == 8'h55, "R12 command wins", int'(col_addr), 8'h55);
        @(negedge clk);
        cmd_valid = 1'b0;
        @(posedge clk); #1;
        chk(!col_valid, "R12 abort held", int'(col_valid), 0);
        @(negedge clk);
        abort = 1'b0;

        // R3 rejected words keep interleave length 8, CL3
        do_mrs(mk(4, 0, 2, 0));
        do_mrs(mk(7, 1, 2, 0));
        do_mrs(mk(2, 0, 0, 0));
        do_mrs(mk(2, 0, 4, 0));
        do_mrs(mk(2, 0, 2, 0) | 12'h080);
        do_mrs(mk(2, 0, 2, 0) | 12'h100);
        do_mrs(mk(2, 0, 2, 0) | 12'h400);
        do_mrs(mk(2, 0, 2, 0) | 12'h800);
        run_burst(1'b0, 8'hC5, 0, 0);

        // constrained random
        for (int it = 0; it < 60; it++) begin
            int bt = int'($urandom % 2);
            int pick = int'($urandom % (bt != 0 ? 4 : 5));
            int bl = (pick == 4) ? 7 : pick;
            if ($urandom % 8 == 0)
                do_mrs(12'($urandom));
            else
                do_mrs(mk(bl, bt, 1 + int'($urandom % 3), ($urandom % 4 == 0) ? 1 : 0));
            run_burst(1'($urandom), int'($urandom % 256), int'($urandom % 3),
                      1 + int'($urandom % 40));
        end
        run_burst(1'b0, 0, 1, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule